// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

A down-counting timer that raises a level interrupt at a fixed rate. Software programs a modulus, picks a power-of-two clock divider and chooses between reloading from the modulus or free-running over the full count range. The counter advances once every 2 x 2^PRE system clocks. A tick that finds the counter at zero reloads it and sets a sticky flag. The interrupt output follows that flag, gated by an enable bit.

Three 16-bit registers sit on a simple write-strobe bus with a combinational read port: control/status at byte offset 0, modulus at offset 2 and the live count at offset 4, which is read-only. Two control bits, debug and doze, are stored and read back but have no effect on counting.

Top module: `pit_timer`

## Requirements
- R1: After reset, control and modulus read 0, the count reads all ones (0xFFFF at the default width), the timer is stopped and `irq` is low.
- R2: The control/status register at offset 0 holds run enable in bit 0, reload select in bit 1, the interrupt flag in bit 2, interrupt enable in bit 3, overwrite in bit 4, debug in bit 5, doze in bit 6 and the prescaler code PRE in bits 11:8. Bits 7 and 15:12 read 0. The modulus is at offset 2 and the count at offset 4.
- R3: While enabled, the count decrements once every 2*2^PRE clocks. While disabled, it holds.
- R4: A tick with the count at 0 reloads the count, from the modulus when reload select is 1 and from all ones when it is 0, and sets the flag.
- R5: `irq` is high exactly when both the flag and interrupt enable are 1.
- R6: Writing 1 to bit 2 at offset 0 clears the flag. Writing 0 there leaves it unchanged.
- R7: Any write to offset 2 clears the flag.
- R8: With overwrite set, a write to offset 2 loads the count in the next cycle. With overwrite clear, the count is untouched and the new modulus is used at the next reload.
- R9: Writes to offset 4 have no effect.
- R10: A control write whose bits 0,1,4,5,6,11:8 equal the stored ones does not disturb the count or the prescaler phase.
- R11: A control write that changes any of bits 0,1,4,5,6,11:8 restarts the prescaler. If the new enable is 1, it also loads the count with the start value chosen by the new reload select.
- R12: Offsets other than 0, 2 and 4 read 0, and writes to them have no effect.
- R13: When the flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with a 10-bit counter (CNT_W=10). A free-running wrap therefore takes about a thousand ticks instead of sixty-five thousand, and both reload paths, including reaching the all-ones start value, fit in a short run. It keeps the prescaler codes small so that many ticks are observed, and it exercises code changes in the middle of a period to show the prescaler restart. Writes are placed on many consecutive cycles around a terminal count so that a flag clear lands on the same edge as a flag set.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  localparam int PRE_W = 4;
  localparam int PS_W  = 1 << PRE_W;

  logic             en_q, rld_q, pif_q, pie_q, ovw_q, dbg_q, doze_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] mod_q, cnt_q;
  logic [PS_W-1:0]  ps_q;

  wire csr_we = bus_we && bus_addr == 3'd0;
  wire mod_we = bus_we && bus_addr == 3'd2;

  wire [15:0] csr_img = {4'b0, pre_q, 1'b0, doze_q, dbg_q, ovw_q, pie_q, pif_q, rld_q, en_q};

  wire restart = csr_we &&
    ({bus_wdata[11:8], bus_wdata[6:4], bus_wdata[1:0]} !=
     {pre_q, doze_q, dbg_q, ovw_q, rld_q, en_q});

  wire [PS_W-1:0]  ps_lim = {PS_W{1'b1}} >> (PRE_W'(PS_W - 1) - pre_q);
  wire             tick   = en_q && ps_q == ps_lim;
  wire             fire   = tick && cnt_q == '0 && !restart;
  wire [CNT_W-1:0] start_cur = rld_q ? mod_q : '1;
  wire [CNT_W-1:0] start_new = bus_wdata[1] ? mod_q : '1;
  wire             flag_clr = (csr_we && bus_wdata[2]) || mod_we;

  assign irq = pif_q & pie_q;

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = csr_img;
      3'd2:    bus_rdata = 16'(mod_q);
      3'd4:    bus_rdata = 16'(cnt_q);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; rld_q <= 1'b0; pie_q <= 1'b0; ovw_q <= 1'b0;
      dbg_q <= 1'b0; doze_q <= 1'b0; pre_q <= '0;
    end else if (csr_we) begin
      en_q   <= bus_wdata[0];
      rld_q  <= bus_wdata[1];
      pie_q  <= bus_wdata[3];
      ovw_q  <= bus_wdata[4];
      dbg_q  <= bus_wdata[5];
      doze_q <= bus_wdata[6];
      pre_q  <= bus_wdata[11:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pif_q <= 1'b0;
    else if (fire)     pif_q <= 1'b1;
    else if (flag_clr) pif_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '0;
    else if (mod_we) mod_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ps_q <= '0;
    else if (restart) ps_q <= '0;
    else if (en_q)    ps_q <= tick ? '0 : ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '1;
    else if (restart) begin
      if (bus_wdata[0])        cnt_q <= start_new;
    end
    else if (mod_we && ovw_q)  cnt_q <= bus_wdata[CNT_W-1:0];
    else if (tick)             cnt_q <= (cnt_q == '0) ? start_cur : cnt_q - 1'b1;
  end
endmodule

module pit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [15:0]      bus_wdata,
  input logic [15:0]      bus_rdata,
  input logic             irq,
  input logic             tick,
  input logic             fire,
  input logic             restart,
  input logic             pif_q,
  input logic             en_q,
  input logic             rld_q,
  input logic             ovw_q,
  input logic [CNT_W-1:0] mod_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R7
  mod_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2 && !fire) |=> !irq);
  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && bus_wdata[2] && !fire) |=> !pif_q);
  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pif_q);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !bus_we) |=> $stable(cnt_q));
  // R9
  ro_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd4 && !tick) |=> $stable(cnt_q));
  // R12
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_addr == 3'd0 || bus_addr == 3'd2 || bus_addr == 3'd4) |-> bus_rdata == 16'h0);
  // R8
  ovw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2 && ovw_q) |=> cnt_q == $past(bus_wdata[CNT_W-1:0]));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rld_q && !bus_we) |=> cnt_q == $past(mod_q));
  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && bus_wdata[0] && !bus_wdata[1]) |=> cnt_q == '1);
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .tick(tick),
  .fire(fire), .restart(restart), .pif_q(pif_q), .en_q(en_q), .rld_q(rld_q),
  .ovw_q(ovw_q), .mod_q(mod_q), .cnt_q(cnt_q)
);

// File: tb/pit_timer_tb.sv
`timescale 1ns/1ps
module pit_timer_tb_top;
  localparam int CNT_W = 10;
  localparam int MASK  = (1 << CNT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  pit_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int    n_vec = 0, n_bad = 0, cycles = 0;
  string req = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_csr, m_mod, m_cnt, m_ps, m_pif;
  int tick_seen = 0;

  function automatic int csr_img();
    return (m_csr & 16'h0F7B) | (m_pif << 2);
  endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return csr_img();
      2: return m_mod;
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_csr = 0; m_mod = 0; m_cnt = MASK; m_ps = 0; m_pif = 0;
    end else begin
      bit en, rst_pre, tk, wr0, wr2;
      int lim, a, d;
      a   = bus_addr; d = bus_wdata; en = m_csr[0];
      wr0 = bus_we && a == 0;
      wr2 = bus_we && a == 2;
      rst_pre = wr0 && (((d ^ m_csr) & 16'h0F73) != 0);
      lim = (2 << ((m_csr >> 8) & 15)) - 1;
      tk  = en && m_ps == lim;
      if (tk) tick_seen++;
      if (tk && m_cnt == 0 && !rst_pre) m_pif = 1;
      else if ((wr0 && d[2]) || wr2) m_pif = 0;
      if (rst_pre) begin
        m_ps = 0;
        if (d[0]) m_cnt = d[1] ? m_mod : MASK;
      end else begin
        if (en) m_ps = tk ? 0 : m_ps + 1;
        if (wr2 && m_csr[4]) m_cnt = d & MASK;
        else if (tk) m_cnt = (m_cnt == 0) ? (m_csr[1] ? m_mod : MASK) : m_cnt - 1;
      end
      if (wr0) m_csr = d & 16'h0F7B;
      if (wr2) m_mod = d & MASK;
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) begin
      int e_irq, e_rd;
      e_irq = m_pif & m_csr[3];
      e_rd  = exp_read(bus_addr);
      n_vec++;
      if (irq !== e_irq[0]) begin
        n_bad++;
        $display("FAIL %s irq: actual %0b expected %0b at cycle %0d", req, irq, e_irq[0], cycles);
      end
      n_vec++;
      if (bus_rdata !== e_rd[15:0]) begin
        n_bad++;
        $display("FAIL %s rdata[off %0d]: actual %h expected %h at cycle %0d",
                 req, bus_addr, bus_rdata, e_rd[15:0], cycles);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk); bus_we = 1'b0; bus_addr = 3'd4;
  endtask

  task automatic look(input int a, input int n);
    @(negedge clk); bus_addr = 3'(a);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; look(0, 2); look(2, 2); look(4, 2);
    req = "R2"; wr(0, 16'hFFFE); look(0, 3); wr(0, 0); look(0, 2);
    req = "R3"; wr(2, 5); wr(0, 16'h0102); look(4, 40);
    req = "R4"; wr(0, 16'h0003); look(4, 30);
    wr(0, 16'h0001); look(4, 2 * (MASK + 8));
    req = "R5"; wr(0, 16'h0009); look(0, 20);
    wr(0, 16'h0001); look(0, 2 * (MASK + 8));
    req = "R6"; wr(0, 16'h0009); look(0, 4); wr(0, 16'h000D); look(0, 4);
    req = "R3"; wr(0, 16'h0000); look(4, 20);
    req = "R7"; wr(2, 2); wr(0, 16'h000B); look(0, 30); wr(2, 2); look(0, 3);
    req = "R8"; wr(0, 16'h001B); wr(2, 40); look(4, 10);
    wr(0, 16'h000B); wr(2, 3); look(4, 200);
    req = "R9"; wr(4, 16'h0123); look(4, 5);
    req = "R10"; wr(0, 16'h0003); look(4, 3); wr(0, 16'h000F); wr(0, 16'h0007); look(4, 20);
    req = "R11"; wr(0, 16'h0207); look(4, 30); wr(0, 16'h0307); look(4, 40); wr(0, 16'h0107); look(4, 20);
    req = "R12"; wr(6, 16'hFFFF); look(6, 3); wr(1, 16'hFFFF); look(7, 2); look(1, 2); look(0, 2);
    req = "R13"; wr(2, 1); wr(0, 16'h000B);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h000F;
    end
    @(negedge clk); bus_we = 1'b0; look(0, 5);
    if (tick_seen == 0) begin
      n_bad++;
      $display("FAIL R3 ticks: actual 0 expected nonzero");
    end
    finish_run();
  end
endmodule